// File: doc/BRIEF.md
# PLL Power-Up Sequencing Controller

This controller steps the analog controls of a single PLL through a safe power-up and power-down order. An enable request raises the supply, releases the isolation clamp, turns on the oscillator and, on instances that have one, releases the PLL's internal reset. A timed wait separates each step. A disable request undoes the same controls in the opposite order, one step per clock cycle, with no waits.

The controller can also load a new feedback control word at any idle point. The word appears on the output with a change flag in its most significant bit, and the controller then waits for the loop to settle before it reports ready again. Requests that arrive while a sequence or a settle wait is running are held and served once the controller is idle. All waits are counted in clock cycles from a parameterized cycles-per-microsecond figure.

Top module: `pll_seq_ctrl`

## Requirements
- R1: After reset, pwr_on_o=0, iso_o=1, base_en_o=0, rst_rel_o=0, ready_o=0 and ctl_word_o is all zero.
- R2: An enable request sampled at a clock edge in the powered-off idle state sets pwr_on_o at that edge.
- R3: iso_o falls SHORT_US*CYC_PER_US cycles after pwr_on_o rises.
- R4: base_en_o rises SHORT_US*CYC_PER_US cycles after iso_o falls.
- R5: LONG_US*CYC_PER_US cycles after base_en_o rises, rst_rel_o rises (only when HAS_RST=1) and ready_o rises in the same cycle.
- R6: A disable request in the enabled idle state produces these changes on consecutive cycles: rst_rel_o falls (only when HAS_RST=1) together with ready_o, then base_en_o falls, then iso_o rises, then pwr_on_o falls.
- R7: A control-word request served in either idle state drives ctl_word_o = {1'b1, cw} for exactly one cycle, then {1'b0, cw}. ready_o stays low for LONG_US*CYC_PER_US cycles from that first cycle, after which the previous idle state returns. cw is the value on cw_i in the cycle of the latest control-word request.
- R8: Enable, disable or control-word requests that arrive during a sequence or a settle wait are held and served in the first cycle after idle is reached.
- R9: A disable request while powered off, and an enable request while fully enabled, change no output.
- R10: When a control-word request and a power request are both pending in idle, the control-word change is served first.
- R11: ready_o is high only when pwr_on_o=1, iso_o=0, base_en_o=1, rst_rel_o matches HAS_RST, and the change flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_req_i | input | 1 | Power-up request pulse |
| dis_req_i | input | 1 | Power-down request pulse |
| cw_req_i | input | 1 | Control-word change request pulse |
| cw_i | input | CW_W | New feedback control word |
| pwr_on_o | output | 1 | PLL supply on |
| iso_o | output | 1 | Isolation clamp active |
| base_en_o | output | 1 | Oscillator enable |
| rst_rel_o | output | 1 | PLL reset released |
| ready_o | output | 1 | Fully enabled and settled |
| ctl_word_o | output | CW_W+1 | Control word, MSB is the one-cycle change flag |

## Verification
On every cycle, the assertions check the ordering invariants. Isolation never drops without supply, and the enable never rises while isolation is on. Reset release needs the enable, and ready implies the full enabled level set. At most one control level moves per cycle, and the change flag never lasts two cycles. Only the bench scenarios can show the exact microsecond spacing between steps, the holding of requests made mid-sequence, the priority of a control-word change over a power request, and that stray requests leave the outputs untouched.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [3:0] {
    ST_OFF, ST_UP_PWR, ST_UP_ISO, ST_UP_EN, ST_ON,
    ST_DN_EN, ST_DN_ISO, ST_DN_PWR, ST_SETTLE
  } seq_state_e;

  localparam int unsigned REQ_CW  = 0;
  localparam int unsigned REQ_EN  = 1;
  localparam int unsigned REQ_DIS = 2;
  localparam int unsigned REQ_N   = 3;
endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pll_seq_req.sv
module pll_seq_req #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] eff_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic pend_q;
    assign eff_o[g] = pend_q | req_i[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= 1'b0;
      else         pend_q <= eff_o[g] & ~clr_i[g];
    end
  end
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 50,
  parameter int unsigned SHORT_US   = 1,
  parameter int unsigned LONG_US    = 20,
  parameter bit          HAS_RST    = 1'b1,
  parameter int unsigned CW_W       = 31
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_req_i,
  input  logic            dis_req_i,
  input  logic            cw_req_i,
  input  logic [CW_W-1:0] cw_i,
  output logic            pwr_on_o,
  output logic            iso_o,
  output logic            base_en_o,
  output logic            rst_rel_o,
  output logic            ready_o,
  output logic [CW_W:0]   ctl_word_o
);
  localparam int unsigned SHORT_CYC = SHORT_US * CYC_PER_US;
  localparam int unsigned LONG_CYC  = LONG_US * CYC_PER_US;
  localparam int unsigned TW        = $clog2(LONG_CYC + 1);
  localparam logic [TW-1:0] SHORT_LD = TW'(SHORT_CYC - 1);
  localparam logic [TW-1:0] LONG_LD  = TW'(LONG_CYC - 1);

  seq_state_e state_q, state_d;
  logic pwr_q, pwr_d, iso_q, iso_d, en_q, en_d, rr_q, rr_d, chg_q, chg_d;
  logic [CW_W-1:0] word_q, word_d, cw_hold_q, cw_data;
  logic [REQ_N-1:0] req, clr, eff;
  logic tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;

  assign req[REQ_CW]  = cw_req_i;
  assign req[REQ_EN]  = en_req_i;
  assign req[REQ_DIS] = dis_req_i;
  assign cw_data      = cw_req_i ? cw_i : cw_hold_q;

  pll_seq_req #(.N(REQ_N)) u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .clr_i(clr), .eff_o(eff)
  );

  pll_seq_timer #(.TW(TW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
    .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    pwr_d    = pwr_q;
    iso_d    = iso_q;
    en_d     = en_q;
    rr_d     = rr_q;
    chg_d    = 1'b0;
    word_d   = word_q;
    clr      = '0;
    tmr_load = 1'b0;
    tmr_val  = LONG_LD;
    unique case (state_q)
      ST_OFF, ST_ON: begin
        if (eff[REQ_CW]) begin
          // control-word change wins over power requests
          clr[REQ_CW] = 1'b1;
          chg_d       = 1'b1;
          word_d      = cw_data;
          tmr_load    = 1'b1;
          state_d     = ST_SETTLE;
        end else if (state_q == ST_OFF) begin
          clr[REQ_DIS] = 1'b1;
          if (eff[REQ_EN]) begin
            clr[REQ_EN] = 1'b1;
            pwr_d       = 1'b1;
            tmr_load    = 1'b1;
            tmr_val     = SHORT_LD;
            state_d     = ST_UP_PWR;
          end
        end else begin
          clr[REQ_EN] = 1'b1;
          if (eff[REQ_DIS]) begin
            clr[REQ_DIS] = 1'b1;
            if (HAS_RST) begin
              rr_d    = 1'b0;
              state_d = ST_DN_EN;
            end else begin
              en_d    = 1'b0;
              state_d = ST_DN_ISO;
            end
          end
        end
      end
      ST_UP_PWR: if (tmr_zero) begin
        iso_d    = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = SHORT_LD;
        state_d  = ST_UP_ISO;
      end
      ST_UP_ISO: if (tmr_zero) begin
        en_d     = 1'b1;
        tmr_load = 1'b1;
        state_d  = ST_UP_EN;
      end
      ST_UP_EN: if (tmr_zero) begin
        rr_d    = HAS_RST;
        state_d = ST_ON;
      end
      ST_DN_EN: begin
        en_d    = 1'b0;
        state_d = ST_DN_ISO;
      end
      ST_DN_ISO: begin
        iso_d   = 1'b1;
        state_d = ST_DN_PWR;
      end
      ST_DN_PWR: begin
        pwr_d   = 1'b0;
        state_d = ST_OFF;
      end
      ST_SETTLE: if (tmr_zero) state_d = en_q ? ST_ON : ST_OFF;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_OFF;
      pwr_q     <= 1'b0;
      iso_q     <= 1'b1;
      en_q      <= 1'b0;
      rr_q      <= 1'b0;
      chg_q     <= 1'b0;
      word_q    <= '0;
      cw_hold_q <= '0;
    end else begin
      state_q   <= state_d;
      pwr_q     <= pwr_d;
      iso_q     <= iso_d;
      en_q      <= en_d;
      rr_q      <= rr_d;
      chg_q     <= chg_d;
      word_q    <= word_d;
      cw_hold_q <= cw_data;
    end
  end

  assign pwr_on_o   = pwr_q;
  assign iso_o      = iso_q;
  assign base_en_o  = en_q;
  assign rst_rel_o  = rr_q;
  assign ready_o    = (state_q == ST_ON);
  assign ctl_word_o = {chg_q, word_q};
endmodule

// File: rtl/pll_seq_ctrl_chk.sv
module pll_seq_ctrl_chk #(
  parameter bit          HAS_RST = 1'b1,
  parameter int unsigned CW_W    = 31
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pwr_on_o,
  input logic          iso_o,
  input logic          base_en_o,
  input logic          rst_rel_o,
  input logic          ready_o,
  input logic [CW_W:0] ctl_word_o
);
  a_r3_iso_needs_pwr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iso_o |-> pwr_on_o);
  a_r4_en_needs_iso_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_en_o |-> !iso_o);
  a_r5_rst_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_rel_o |-> base_en_o);
  a_r6_en_fall_after_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(base_en_o) |-> !rst_rel_o);
  a_r6_iso_rise_with_pwr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iso_o) |-> (pwr_on_o && !base_en_o));
  a_r6_pwr_fall_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_on_o) |-> iso_o);
  a_r6_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({$changed(pwr_on_o), $changed(iso_o),
                $changed(base_en_o), $changed(rst_rel_o)}) <= 1);
  a_r7_flag_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_word_o[CW_W] |=> !ctl_word_o[CW_W]);
  a_r11_ready_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (pwr_on_o && !iso_o && base_en_o &&
                 (rst_rel_o == HAS_RST) && !ctl_word_o[CW_W]));
endmodule

bind pll_seq_ctrl pll_seq_ctrl_chk #(.HAS_RST(HAS_RST), .CW_W(CW_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_on_o(pwr_on_o), .iso_o(iso_o),
  .base_en_o(base_en_o), .rst_rel_o(rst_rel_o), .ready_o(ready_o),
  .ctl_word_o(ctl_word_o)
);

// File: tb/pll_seq_ctrl_test.sv
module pll_seq_ctrl_test;
  localparam int unsigned CPU  = 4;
  localparam int unsigned CW_W = 31;
  localparam int S  = CPU * 1;
  localparam int L  = CPU * 20;
  localparam int VW = 5 + CW_W + 1;

  typedef struct {
    int              cyc;
    logic [VW-1:0]   v;
    string           tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_req = 1'b0, dis_req = 1'b0, cw_req = 1'b0;
  logic [CW_W-1:0] cw = '0;
  logic pwr, iso, en, rr, rdy;
  logic [CW_W:0] word;

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  exp_t q[$];
  logic [VW-1:0] prev;
  bit mon_on = 1'b0;

  // bench model of expected output levels
  logic m_pwr = 0, m_iso = 1, m_en = 0, m_rr = 0, m_rdy = 0, m_chg = 0;
  logic [CW_W-1:0] m_word = '0;

  pll_seq_ctrl #(.CYC_PER_US(CPU), .SHORT_US(1), .LONG_US(20),
                 .HAS_RST(1'b1), .CW_W(CW_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_req_i(en_req), .dis_req_i(dis_req),
    .cw_req_i(cw_req), .cw_i(cw), .pwr_on_o(pwr), .iso_o(iso),
    .base_en_o(en), .rst_rel_o(rr), .ready_o(rdy), .ctl_word_o(word)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [VW-1:0] dut_vec();
    return {rdy, rr, en, iso, pwr, word};
  endfunction

  function automatic logic [VW-1:0] mdl_vec();
    return {m_rdy, m_rr, m_en, m_iso, m_pwr, m_chg, m_word};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp_v, cyc);
    end
  endtask

  task automatic push(input int c, input string tag);
    exp_t e;
    e.cyc = c; e.v = mdl_vec(); e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: every output change must match the head of the queue
  always @(negedge clk) begin
    if (mon_on) begin
      logic [VW-1:0] v;
      v = dut_vec();
      if (v != prev) begin
        if (q.size() == 0) begin
          check(1'b0, "R9 unexpected change", v, prev);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(v == e.v && cyc == e.cyc, e.tag, v, e.v);
          if (cyc != e.cyc) $display("     %s seen at cycle %0d, due %0d", e.tag, cyc, e.cyc);
        end
        prev = v;
      end
    end
  end

  task automatic pulse(input bit e, input bit d, input bit w,
                       input logic [CW_W-1:0] data, output int c);
    @(negedge clk);
    c = cyc;
    en_req = e; dis_req = d; cw_req = w;
    if (w) cw = data;
    @(negedge clk);
    en_req = 0; dis_req = 0; cw_req = 0;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic expect_up(input int c0);
    m_pwr = 1; push(c0, "R2 power on");
    m_iso = 0; push(c0 + S, "R3 isolation off");
    m_en = 1;  push(c0 + 2*S, "R4 base enable");
    m_rr = 1; m_rdy = 1; push(c0 + 2*S + L, "R5 reset release and ready");
  endtask

  task automatic expect_down(input int c0);
    m_rr = 0; m_rdy = 0; push(c0, "R6 reset release off");
    m_en = 0;  push(c0 + 1, "R6 enable off");
    m_iso = 1; push(c0 + 2, "R6 isolation on");
    m_pwr = 0; push(c0 + 3, "R6 power off");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int c, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dut_vec() == mdl_vec(), "R1 reset state", dut_vec(), mdl_vec());
    prev = dut_vec();
    mon_on = 1'b1;

    // R9: disable while off does nothing
    pulse(0, 1, 0, '0, c);
    wait_to(c + 12);
    check(dut_vec() == mdl_vec(), "R9 disable while off", dut_vec(), mdl_vec());

    // R2..R5: power-up timing
    pulse(1, 0, 0, '0, c);
    expect_up(c + 1);
    wait_to(c + 2*S + L + 4);
    check(rdy == 1'b1, "R11 ready after up", dut_vec(), mdl_vec());

    // R9: enable while on does nothing
    pulse(1, 0, 0, '0, c);
    wait_to(c + 12);
    check(dut_vec() == mdl_vec(), "R9 enable while on", dut_vec(), mdl_vec());

    // R7: control-word change while on
    pulse(0, 0, 1, 31'h2A5A_1234, c);
    m_chg = 1; m_word = 31'h2A5A_1234; m_rdy = 0; push(c + 1, "R7 word with flag");
    m_chg = 0; push(c + 2, "R7 flag clears");
    m_rdy = 1; push(c + 1 + L, "R7 settle done");
    wait_to(c + L + 4);

    // R6: power-down order
    pulse(0, 1, 0, '0, c);
    expect_down(c + 1);
    wait_to(c + 8);
    check(dut_vec() == mdl_vec(), "R1 back to off levels", dut_vec(), mdl_vec());

    // R8: disable arriving mid power-up is held
    pulse(1, 0, 0, '0, c);
    expect_up(c + 1);
    t = c + 1 + 2*S + L;
    wait_to(c + 5);
    pulse(0, 1, 0, '0, c);
    expect_down(t + 1);
    wait_to(t + 8);
    check(dut_vec() == mdl_vec(), "R8 held disable served", dut_vec(), mdl_vec());

    // R10 + R8: change and enable together while off; change first
    pulse(1, 0, 1, 31'h0155_00AA, c);
    m_chg = 1; m_word = 31'h0155_00AA; push(c + 1, "R10 change served first");
    m_chg = 0; push(c + 2, "R7 flag clears while off");
    expect_up(c + 2 + L);
    t = c + 2 + 2*S + 2*L;
    wait_to(t + 3);
    check(rdy == 1'b1, "R8 held enable served", dut_vec(), mdl_vec());

    pulse(0, 1, 0, '0, c);
    expect_down(c + 1);
    wait_to(c + 8);

    check(q.size() == 0, "R6 all expected events seen", VW'(q.size()), '0);
    check(dut_vec() == mdl_vec(), "R1 final off levels", dut_vec(), mdl_vec());
    done = 1'b1;
    finish_run();
  end
endmodule